// File: doc/BRIEF.md
# Display Pin Mode Gate and Port Router

This block sits between the waveform sources of a multiplexed LCD driver and its output pins. It takes the common waveforms, the segment waveforms, a matching set of segment-off (blank) waveforms and three PWM channel waveforms, and decides what each pin finally carries. The decision is set by a small set of mode bits: drive with a single common or with all four commons, blank the segments, sleep, and pick the clock source. For each of the twelve lowest segment pins, a per-pin map says whether that pin is a segment or a general-purpose port. A port pin then shows either a programmed high/low level or one of the three PWM channels.

All control inputs are captured into shadow registers on a one-cycle load strobe. A mode change therefore takes effect at a single clock edge and never part-way through a control update. The waveforms themselves pass through combinational gating. The block also produces the enable for the internal oscillator or the external clock receiver, and the drive enable of the one segment pin that doubles as the external clock input.

Top module: `lcd_pin_router`

## Requirements
- R1: Control inputs reach the outputs only on the rising clock edge where `load` is 1; while `load` is 0, changes on any `cfg_*` input leave every output unchanged.
- R2: After reset, and until the first load, the block is in sleep with the internal clock source: all commons and segments are 0, both clock enables are 0, and `clkpin_seg_oe` is 1.
- R3: With `cfg_single_com`=1 and no sleep, commons 1 to NCOM-1 are held at 0 and common 0 carries `com_wave[0]`.
- R4: With `cfg_single_com`=0 and no sleep, every common carries its `com_wave` bit.
- R5: With `cfg_blank`=1 and no sleep, each segment pin that is neither a port nor the clock-input pin carries its `seg_off_wave` bit; with `cfg_blank`=0 it carries its `seg_wave` bit.
- R6: With `cfg_sleep`=1, all commons and all non-port segment pins are 0, and both `osc_run` and `ext_clk_en` are 0.
- R7: With `cfg_ext_clk`=0, `osc_run` equals not-sleep, `ext_clk_en` is 0 and `clkpin_seg_oe` is 1. With `cfg_ext_clk`=1, `ext_clk_en` equals not-sleep, `osc_run` is 0, `clkpin_seg_oe` is 0 and segment pin CLK_PIN outputs 0.
- R8: Port n's select pair is A=`cfg_port_sel[2n]`, B=`cfg_port_sel[2n+1]`. With PWM routing allowed, (A,B)=(1,0) outputs `pwm_wave[0]`, (0,1) outputs `pwm_wave[1]` and (1,1) outputs `pwm_wave[2]`.
- R9: A port pin with (A,B)=(0,0) outputs its `cfg_gp_level` bit in every mode.
- R10: In sleep, PWM routing is blocked and a port pin outputs its `cfg_gp_level` bit whatever its select pair.
- R11: With `cfg_ext_clk`=1 and `cfg_ext_slow`=1, PWM routing is blocked on every port pin, which then outputs its `cfg_gp_level` bit.
- R12: For a pin with `cfg_port_map` bit 0, its select pair and level bit have no effect and the pin follows the segment rules of R5 and R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Capture strobe for all `cfg_*` inputs |
| cfg_single_com | input | 1 | 1: static drive, upper commons held low |
| cfg_blank | input | 1 | 1: segments show the off waveform |
| cfg_sleep | input | 1 | 1: power saving |
| cfg_ext_clk | input | 1 | 1: external clock source, shared pin becomes clock input |
| cfg_ext_slow | input | 1 | 1: external clock is the slow rate (blocks PWM when `cfg_ext_clk`=1) |
| cfg_port_map | input | NPORT | Per shared pin: 1 = port, 0 = segment |
| cfg_gp_level | input | NPORT | General-purpose level of each port |
| cfg_port_sel | input | 2*NPORT | Select pair per port, A in the even bit, B in the odd bit |
| com_wave | input | NCOM | Multiplexed common waveforms |
| seg_wave | input | NSEG | Segment display waveforms |
| seg_off_wave | input | NSEG | Segment-off waveforms |
| pwm_wave | input | 3 | PWM channel 1..3 waveforms |
| com_out | output | NCOM | Common pin drive |
| seg_out | output | NSEG | Segment / port pin drive |
| clkpin_seg_oe | output | 1 | Drive enable of segment pin CLK_PIN |
| osc_run | output | 1 | Internal oscillator enable |
| ext_clk_en | output | 1 | External clock receiver enable |

## Verification
The hardest case to reach is a port pin that names a PWM channel while routing is blocked. Two separate conditions block routing, sleep and the slow external clock, and the select pair must be non-zero while the level bit differs from the PWM waveform. The bench sweeps all 32 mode-bit combinations. In each one it rotates the select pair across the pins, so that every pin sees all four codes, and drives two PWM patterns that disagree with the level bits. A blocked route then always shows up as a level mismatch. Hold behaviour is reached by changing every control input with the strobe low and comparing against the last committed settings.

// File: rtl/lpr_pkg.sv
// Shared types for the display pin router.
// Assumes: the select pair is packed as {B, A}.
package lpr_pkg;

    // Port function code as {B, A}
    typedef enum logic [1:0] {
        PSEL_LEVEL = 2'b00,
        PSEL_PWM1  = 2'b01,
        PSEL_PWM2  = 2'b10,
        PSEL_PWM3  = 2'b11
    } port_sel_e;

    // Mode bits held in the shadow register
    typedef struct packed {
        logic single_com;
        logic blank;
        logic sleep;
        logic ext_clk;
        logic ext_slow;
    } mode_t;

    localparam mode_t MODE_RESET = '{single_com: 1'b0, blank: 1'b0, sleep: 1'b1,
                                     ext_clk: 1'b0, ext_slow: 1'b0};

endpackage

// File: rtl/lpr_shadow.sv
// Shadow register bank: captures all control inputs on the load strobe.
// Assumes: load is a synchronous one-cycle strobe. Reset enters sleep with the internal clock.
module lpr_shadow
    import lpr_pkg::*;
#(
    parameter int NPORT = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  mode_t              mode_d,
    input  logic [NPORT-1:0]   map_d,
    input  logic [NPORT-1:0]   lvl_d,
    input  logic [2*NPORT-1:0] sel_d,
    output mode_t              mode_q,
    output logic [NPORT-1:0]   map_q,
    output logic [NPORT-1:0]   lvl_q,
    output logic [2*NPORT-1:0] sel_q
);

    // Capture the whole control set on load, so modes switch together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RESET;
            map_q  <= '0;
            lvl_q  <= '0;
            sel_q  <= '0;
        end else if (load) begin
            mode_q <= mode_d;
            map_q  <= map_d;
            lvl_q  <= lvl_d;
            sel_q  <= sel_d;
        end
    end

endmodule

// File: rtl/lpr_com_gate.sv
// Common line gate: sleep forces every common low. Static drive forces all but common 0 low.
// Assumes: common 0 is the line that stays active in static drive.
module lpr_com_gate #(
    parameter int NCOM = 4
) (
    input  logic            single_com,
    input  logic            sleep,
    input  logic [NCOM-1:0] com_wave,
    output logic [NCOM-1:0] com_out
);

    for (genvar k = 0; k < NCOM; k++) begin : g_com
        if (k == 0) begin : g_base
            // Base common: low only in sleep
            always_comb com_out[k] = sleep ? 1'b0 : com_wave[k];
        end else begin : g_upper
            // Upper commons: low in sleep or in static drive
            always_comb com_out[k] = (sleep || single_com) ? 1'b0 : com_wave[k];
        end
    end

endmodule

// File: rtl/lpr_port_mux.sv
// Port level selector: for each shared pin, picks the programmed level or one PWM channel.
// Assumes: pwm_block already combines every mode that forbids PWM routing.
module lpr_port_mux
    import lpr_pkg::*;
#(
    parameter int NPORT = 12,
    parameter int NPWM  = 3
) (
    input  logic               pwm_block,
    input  logic [NPORT-1:0]   lvl,
    input  logic [2*NPORT-1:0] sel,
    input  logic [NPWM-1:0]    pwm_wave,
    output logic [NPORT-1:0]   port_level
);

    for (genvar n = 0; n < NPORT; n++) begin : g_port
        port_sel_e code;
        assign code = port_sel_e'(sel[2*n +: 2]);

        // Choose the source of port n; a blocked route falls back to the level
        always_comb begin
            if (pwm_block) begin
                port_level[n] = lvl[n];
            end else begin
                unique case (code)
                    PSEL_PWM1: port_level[n] = pwm_wave[0];
                    PSEL_PWM2: port_level[n] = pwm_wave[1];
                    PSEL_PWM3: port_level[n] = pwm_wave[2];
                    default:   port_level[n] = lvl[n];
                endcase
            end
        end
    end

endmodule

// File: rtl/lpr_seg_gate.sv
// Segment pin gate: port pins take the port level. The clock pin is released in
// external clock mode. The other pins are low in sleep, else blank or display.
// Assumes: CLK_PIN >= NPORT, so the clock-sharing pin is never a port.
module lpr_seg_gate #(
    parameter int NSEG    = 40,
    parameter int NPORT   = 12,
    parameter int CLK_PIN = 36
) (
    input  logic             blank,
    input  logic             sleep,
    input  logic             ext_clk,
    input  logic [NPORT-1:0] port_map,
    input  logic [NPORT-1:0] port_level,
    input  logic [NSEG-1:0]  seg_wave,
    input  logic [NSEG-1:0]  seg_off_wave,
    output logic [NSEG-1:0]  seg_out,
    output logic             clkpin_seg_oe
);

    logic [NSEG-1:0] seg_plain;

    for (genvar i = 0; i < NSEG; i++) begin : g_pin
        // Segment waveform after sleep and blanking
        always_comb seg_plain[i] = sleep ? 1'b0 : (blank ? seg_off_wave[i] : seg_wave[i]);

        if (i < NPORT) begin : g_shared
            // Shared pin: port level when mapped as a port
            always_comb seg_out[i] = port_map[i] ? port_level[i] : seg_plain[i];
        end else if (i == CLK_PIN) begin : g_clkpin
            // Clock-sharing pin: driven low and released while it is the clock input
            always_comb seg_out[i] = ext_clk ? 1'b0 : seg_plain[i];
        end else begin : g_seg
            // Plain segment pin
            always_comb seg_out[i] = seg_plain[i];
        end
    end

    // The drive of the shared clock pin is enabled only with the internal clock source
    always_comb clkpin_seg_oe = !ext_clk;

endmodule

// File: rtl/lcd_pin_router.sv
// Top level: shadow registers, then mode gating of commons, segments and ports,
// plus the clock source enables.
// Assumes: the waveform inputs are synchronous to clk and already settled.
module lcd_pin_router
    import lpr_pkg::*;
#(
    parameter int NCOM    = 4,
    parameter int NSEG    = 40,
    parameter int NPORT   = 12,
    parameter int CLK_PIN = 36
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               cfg_single_com,
    input  logic               cfg_blank,
    input  logic               cfg_sleep,
    input  logic               cfg_ext_clk,
    input  logic               cfg_ext_slow,
    input  logic [NPORT-1:0]   cfg_port_map,
    input  logic [NPORT-1:0]   cfg_gp_level,
    input  logic [2*NPORT-1:0] cfg_port_sel,
    input  logic [NCOM-1:0]    com_wave,
    input  logic [NSEG-1:0]    seg_wave,
    input  logic [NSEG-1:0]    seg_off_wave,
    input  logic [2:0]         pwm_wave,
    output logic [NCOM-1:0]    com_out,
    output logic [NSEG-1:0]    seg_out,
    output logic               clkpin_seg_oe,
    output logic               osc_run,
    output logic               ext_clk_en
);

    localparam int NPWM = 3;

    mode_t              mode_d, mode_q;
    logic [NPORT-1:0]   map_q, lvl_q, port_level;
    logic [2*NPORT-1:0] sel_q;
    logic               pwm_block;

    // Gather the mode inputs into one record
    always_comb mode_d = '{single_com: cfg_single_com, blank: cfg_blank, sleep: cfg_sleep,
                           ext_clk: cfg_ext_clk, ext_slow: cfg_ext_slow};

    lpr_shadow #(.NPORT(NPORT)) u_shadow (
        .clk(clk), .rst_n(rst_n), .load(load),
        .mode_d(mode_d), .map_d(cfg_port_map), .lvl_d(cfg_gp_level), .sel_d(cfg_port_sel),
        .mode_q(mode_q), .map_q(map_q), .lvl_q(lvl_q), .sel_q(sel_q)
    );

    // PWM routing is unavailable in sleep and with the slow external clock
    always_comb pwm_block = mode_q.sleep || (mode_q.ext_clk && mode_q.ext_slow);

    // Exactly one clock source may run, and none in sleep
    always_comb begin
        osc_run    = !mode_q.sleep && !mode_q.ext_clk;
        ext_clk_en = !mode_q.sleep &&  mode_q.ext_clk;
    end

    lpr_com_gate #(.NCOM(NCOM)) u_com (
        .single_com(mode_q.single_com), .sleep(mode_q.sleep),
        .com_wave(com_wave), .com_out(com_out)
    );

    lpr_port_mux #(.NPORT(NPORT), .NPWM(NPWM)) u_port (
        .pwm_block(pwm_block), .lvl(lvl_q), .sel(sel_q),
        .pwm_wave(pwm_wave), .port_level(port_level)
    );

    lpr_seg_gate #(.NSEG(NSEG), .NPORT(NPORT), .CLK_PIN(CLK_PIN)) u_seg (
        .blank(mode_q.blank), .sleep(mode_q.sleep), .ext_clk(mode_q.ext_clk),
        .port_map(map_q), .port_level(port_level),
        .seg_wave(seg_wave), .seg_off_wave(seg_off_wave),
        .seg_out(seg_out), .clkpin_seg_oe(clkpin_seg_oe)
    );

endmodule

// File: rtl/lpr_checker.sv
// Property checker for lcd_pin_router, bound to every instance of the top.
// Assumes: it is connected to the top's ports and to its shadow mode state.
module lpr_checker #(
    parameter int NCOM    = 4,
    parameter int NSEG    = 40,
    parameter int NPORT   = 12,
    parameter int CLK_PIN = 36
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic             sh_single,
    input logic             sh_sleep,
    input logic             sh_ext,
    input logic             sh_slow,
    input logic [NPORT-1:0] sh_map,
    input logic [NPORT-1:0] sh_lvl,
    input logic [NCOM-1:0]  com_out,
    input logic [NSEG-1:0]  seg_out,
    input logic             clkpin_seg_oe,
    input logic             osc_run,
    input logic             ext_clk_en
);

    // R1: shadow mode holds while no load is seen
    p_hold_without_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(sh_single) && $stable(sh_sleep) && $stable(sh_ext) && $stable(sh_slow)))
        else $error("p_hold_without_load_r1");

    // R3: upper commons low in static drive
    p_static_upper_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sh_single |-> com_out[NCOM-1:1] == '0)
        else $error("p_static_upper_low_r3");

    // R6: sleep silences every common
    p_sleep_com_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sh_sleep |-> (com_out == '0 && !osc_run && !ext_clk_en))
        else $error("p_sleep_com_low_r6");

    // R7: never both clock sources enabled
    p_one_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(osc_run && ext_clk_en))
        else $error("p_one_clock_r7");

    // R7: clock pin released and low with the external source
    p_clkpin_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sh_ext |-> (!clkpin_seg_oe && !seg_out[CLK_PIN]))
        else $error("p_clkpin_release_r7");

    // R10 and R11: blocked routing leaves ports at their levels
    p_blocked_ports_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_sleep || (sh_ext && sh_slow)) |-> (((seg_out[NPORT-1:0] ^ sh_lvl) & sh_map) == '0))
        else $error("p_blocked_ports_level_r10");

endmodule

bind lcd_pin_router lpr_checker #(
    .NCOM(NCOM), .NSEG(NSEG), .NPORT(NPORT), .CLK_PIN(CLK_PIN)
) u_lpr_checker (
    .clk(clk), .rst_n(rst_n), .load(load),
    .sh_single(mode_q.single_com), .sh_sleep(mode_q.sleep),
    .sh_ext(mode_q.ext_clk), .sh_slow(mode_q.ext_slow),
    .sh_map(map_q), .sh_lvl(lvl_q),
    .com_out(com_out), .seg_out(seg_out), .clkpin_seg_oe(clkpin_seg_oe),
    .osc_run(osc_run), .ext_clk_en(ext_clk_en)
);

// File: tb/test_lcd_pin_router.sv
// Bench: sweeps every mode combination with rotating port selects. The expected pins
// come from the requirement rules applied to the last committed settings.
module test_lcd_pin_router;

    localparam int NCOM = 4, NSEG = 40, NPORT = 12, CLKP = 36;

    logic clk = 1'b0, rst_n = 1'b0, load = 1'b0;
    logic i_single = 0, i_blank = 0, i_sleep = 0, i_ext = 0, i_slow = 0;
    logic [NPORT-1:0] i_map = '0, i_lvl = '0;
    logic [2*NPORT-1:0] i_sel = '0;
    logic [NCOM-1:0] com_w = '0;
    logic [NSEG-1:0] seg_w = '0, off_w = '0;
    logic [2:0] pwm_w = '0;
    logic [NCOM-1:0] com_out;
    logic [NSEG-1:0] seg_out;
    logic clkpin_seg_oe, osc_run, ext_clk_en;

    // committed settings, as the bench believes the block holds them
    logic c_single, c_blank, c_sleep, c_ext, c_slow;
    logic [NPORT-1:0] c_map, c_lvl;
    logic [2*NPORT-1:0] c_sel;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lcd_pin_router #(.NCOM(NCOM), .NSEG(NSEG), .NPORT(NPORT), .CLK_PIN(CLKP)) i_lcd_pin_router (
        .clk(clk), .rst_n(rst_n), .load(load),
        .cfg_single_com(i_single), .cfg_blank(i_blank), .cfg_sleep(i_sleep),
        .cfg_ext_clk(i_ext), .cfg_ext_slow(i_slow),
        .cfg_port_map(i_map), .cfg_gp_level(i_lvl), .cfg_port_sel(i_sel),
        .com_wave(com_w), .seg_wave(seg_w), .seg_off_wave(off_w), .pwm_wave(pwm_w),
        .com_out(com_out), .seg_out(seg_out), .clkpin_seg_oe(clkpin_seg_oe),
        .osc_run(osc_run), .ext_clk_en(ext_clk_en)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NCOM-1:0] exp_com();
        logic [NCOM-1:0] v;
        for (int k = 0; k < NCOM; k++)
            v[k] = c_sleep ? 1'b0 : ((c_single && k > 0) ? 1'b0 : com_w[k]);
        return v;
    endfunction

    function automatic logic exp_plain(input int k);
        if (k == CLKP && c_ext) return 1'b0;
        if (c_sleep) return 1'b0;
        return c_blank ? off_w[k] : seg_w[k];
    endfunction

    function automatic logic exp_port(input int n);
        int code;
        code = int'({c_sel[2*n+1], c_sel[2*n]});
        if (code == 0 || c_sleep || (c_ext && c_slow)) return c_lvl[n];
        return pwm_w[code-1];
    endfunction

    // Compare every output against the rules; tag picks the rule under test
    task automatic check_all(input string tag);
        logic [NSEG-1:0] ev;
        string ptag;
        check({tag, (c_sleep ? " R6 com" : (c_single ? " R3 com" : " R4 com"))},
              64'(com_out), 64'(exp_com()));
        for (int k = NPORT; k < NSEG; k++) ev[k] = exp_plain(k);
        check({tag, (c_sleep ? " R6 seg" : " R5 seg")},
              64'(seg_out[NSEG-1:NPORT]), 64'(ev[NSEG-1:NPORT]));
        for (int n = 0; n < NPORT; n++) begin
            if (!c_map[n]) begin
                ptag = " R12 unmapped pin";
                check({tag, ptag}, 64'(seg_out[n]), 64'(exp_plain(n)));
            end else begin
                if ({c_sel[2*n+1], c_sel[2*n]} == 2'b00) ptag = " R9 level port";
                else if (c_sleep) ptag = " R10 sleep port";
                else if (c_ext && c_slow) ptag = " R11 slow clock port";
                else ptag = " R8 pwm port";
                check({tag, ptag}, 64'(seg_out[n]), 64'(exp_port(n)));
            end
        end
        check({tag, " R7 clkpin oe"}, 64'(clkpin_seg_oe), 64'(!c_ext));
        check({tag, " R7 osc_run"}, 64'(osc_run), 64'(!c_sleep && !c_ext));
        check({tag, " R7 ext_clk_en"}, 64'(ext_clk_en), 64'(!c_sleep && c_ext));
    endtask

    // Strobe load for one edge and commit the settings in the bench model
    task automatic do_load();
        @(negedge clk);
        load = 1'b1;
        @(posedge clk);
        c_single = i_single; c_blank = i_blank; c_sleep = i_sleep; c_ext = i_ext; c_slow = i_slow;
        c_map = i_map; c_lvl = i_lvl; c_sel = i_sel;
        @(negedge clk);
        load = 1'b0;
        #1;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R2: reset state, with waveforms all ones so any leak is visible
        com_w = '1; seg_w = '1; off_w = '1; pwm_w = '1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check("R2 com", 64'(com_out), 64'd0);
        check("R2 seg", 64'(seg_out), 64'd0);
        check("R2 osc_run", 64'(osc_run), 64'd0);
        check("R2 ext_clk_en", 64'(ext_clk_en), 64'd0);
        check("R2 clkpin oe", 64'(clkpin_seg_oe), 64'd1);

        // Sweep all mode combinations, select rotations and waveform patterns
        for (int m = 0; m < 32; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int w = 0; w < 2; w++) begin
                    i_single = m[0]; i_blank = m[1]; i_sleep = m[2]; i_ext = m[3]; i_slow = m[4];
                    i_map = NPORT'(12'hA6D ^ (m * 37 + s * 5));
                    i_lvl = NPORT'(12'h5B3 ^ (m * 11 + w * 99));
                    for (int n = 0; n < NPORT; n++) i_sel[2*n +: 2] = 2'((s + n) % 4);
                    do_load();
                    com_w = w ? 4'b1011 : 4'b0111;
                    seg_w = w ? 40'hA5_C3F0_0FF1 : 40'h3C_5AA5_F00E;
                    off_w = ~seg_w;
                    pwm_w = 3'((m + s + w) % 8);
                    #1;
                    check_all("sweep");
                    pwm_w = ~pwm_w;
                    #1;
                    check_all("sweep inverted pwm");
                end
            end
            // R1: change every control input without load; outputs must not move
            i_single = ~i_single; i_blank = ~i_blank; i_sleep = ~i_sleep;
            i_ext = ~i_ext; i_slow = ~i_slow;
            i_map = ~i_map; i_lvl = ~i_lvl; i_sel = ~i_sel;
            @(posedge clk);
            @(negedge clk);
            #1;
            check_all("R1 hold");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule